// File: doc/BRIEF.md
# External Interrupt Request Detector

This block turns two asynchronous, active-low interrupt pins into request flags for a downstream interrupt controller. Each pin is brought into the clock domain through a two-stage synchroniser. Software picks the trigger type for each pin. In falling-edge mode the block latches a request when it sees a transition from high to low. In level mode the request simply tracks the pin while the pin is held low.

Software sees and changes the block through a four-bit control nibble. For each pin the nibble holds a trigger-type bit and a request-flag bit. A latched edge request is cleared by hardware when the processor acknowledges the vector address that belongs to that pin. A software write can also set or clear either flag directly. The two request flags leave the block as `irq_req` for enable masking and prioritisation further down the line. That masking and prioritisation is not part of this block.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset both request flags and both type bits read 0, and `irq_req` is 0 while the pins idle high.
- R2: `rd_data` has this bit layout: bit 0 is the type of pin 0, bit 1 is the flag of pin 0, bit 2 is the type of pin 1, and bit 3 is the flag of pin 1. `irq_req[n]` equals the flag of pin n. A type value of 1 selects falling-edge mode and 0 selects level mode.
- R3: In falling-edge mode, a pin that goes from high to low before clock edge k shows its flag set after edge k+2. A pin that stays low or that rises sets nothing.
- R4: A latched edge flag stays set until `ack_valid` is high with `ack_addr` equal to that pin's vector: 16'h0003 for pin 0 and 16'h0013 for pin 1. The flag is then 0 after that edge.
- R5: An acknowledge carrying any other address leaves the flags unchanged, and so does the other pin's vector.
- R6: When a falling edge is detected in the same cycle as the matching acknowledge, the flag stays set.
- R7: In level mode, the flag after edge k equals the inverse of the pin as sampled before edge k-2. An acknowledge has no lasting effect on it.
- R8: When `wr_en` is high, each flag and each type bit takes the value of its `wr_data` bit at that edge. This wins over a falling-edge set and over an acknowledge in the same cycle.
- R9: The two pins are independent. Stimulus on one pin, an acknowledge of one pin's vector, or a change to one pin's type never changes the other pin's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | 2 | Asynchronous active-low interrupt pins |
| wr_en | input | 1 | Write strobe for the control nibble |
| wr_data | input | 4 | Write data: {flag1, type1, flag0, type0} |
| rd_data | output | 4 | Read data, same layout as wr_data |
| ack_valid | input | 1 | Vector acknowledge strobe |
| ack_addr | input | 16 | Address of the acknowledged vector |
| irq_req | output | 2 | Request flags to the interrupt controller |

## Verification
The bench times each falling edge so that it lands in the same cycle as its own acknowledge. A design that lets the acknowledge win here loses an interrupt. It also times a software write to coincide with a detected edge. A design that lets the hardware set win here leaves a flag that software believed it had cleared. In level mode the bench acknowledges while the pin is still low, to catch a design that wrongly latches the clear. It also sends the other pin's vector and stray addresses, to catch an address decode that is too loose. Random pin, write and acknowledge traffic runs against a cycle model to catch latency slips in the synchroniser and in the edge detector.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  localparam int unsigned NUM_CH      = 2;
  localparam int unsigned BITS_PER_CH = 2;
  localparam int unsigned CTRL_W      = NUM_CH * BITS_PER_CH;
  localparam int unsigned VEC_W       = 16;
  localparam int unsigned VEC_BASE    = 3;
  localparam int unsigned VEC_STEP    = 16;

  typedef enum logic {TRIG_LEVEL = 1'b0, TRIG_FALL = 1'b1} trig_e;

  // vector address owned by channel ch
  function automatic logic [VEC_W-1:0] chan_vector(input int unsigned ch);
    return VEC_W'(VEC_BASE + VEC_STEP * ch);
  endfunction

  // high-to-low transition between two synchronised samples
  function automatic logic fall_seen(input logic older, input logic newer);
    return older & ~newer;
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shreg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) shreg <= '1;
        else        shreg <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) shreg <= '1;
        else        shreg <= {shreg[STAGES-2:0], d};
    end
  endgenerate

  assign q = shreg[STAGES-1];
endmodule

// File: rtl/irq_chan.sv
module irq_chan
  import extirq_pkg::*;
#(
  parameter logic [VEC_W-1:0] VEC = 16'h0003
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl,
  input  logic             wr_en,
  input  logic             wr_type,
  input  logic             wr_flag,
  input  logic             ack_valid,
  input  logic [VEC_W-1:0] ack_addr,
  output trig_e            trig_o,
  output logic             flag_o
);
  logic  prev_lvl;
  trig_e trig_q;
  logic  flag_q;
  logic  fall_evt;
  logic  ack_hit;
  logic  edge_mode;

  assign fall_evt  = fall_seen(prev_lvl, lvl);
  assign ack_hit   = ack_valid && (ack_addr == VEC);
  assign edge_mode = (trig_q == TRIG_FALL);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_lvl <= 1'b1;
    else        prev_lvl <= lvl;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     trig_q <= TRIG_LEVEL;
    else if (wr_en) trig_q <= trig_e'(wr_type);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag_q <= 1'b0;
    else if (wr_en)      flag_q <= wr_flag;
    else if (edge_mode) begin
      if (fall_evt)      flag_q <= 1'b1;
      else if (ack_hit)  flag_q <= 1'b0;
    end else             flag_q <= ~lvl;
  end

  assign trig_o = trig_q;
  assign flag_o = flag_q;

  // R4: matching acknowledge clears an edge flag
  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && !wr_en && ack_hit && !fall_evt) |=> !flag_q);
  // R5: no event, no change in edge mode
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && !wr_en && !ack_hit && !fall_evt) |=> $stable(flag_q));
  // R6: detected edge beats acknowledge
  a_r6_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && !wr_en && fall_evt) |=> flag_q);
  // R7: level mode follows the inverted synchronised pin
  a_r7_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_mode && !wr_en) |=> (flag_q == !$past(lvl)));
  // R8: software write wins
  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (flag_q == $past(wr_flag)) && (trig_q == trig_e'($past(wr_type))));
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import extirq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] irq_pin_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  input  logic              ack_valid,
  input  logic [VEC_W-1:0]  ack_addr,
  output logic [NUM_CH-1:0] irq_req
);
  logic  [NUM_CH-1:0] lvl_sync;
  trig_e              trig [NUM_CH];
  logic  [NUM_CH-1:0] flag;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (irq_pin_n[ch]),
      .q     (lvl_sync[ch])
    );

    irq_chan #(.VEC(chan_vector(ch))) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .lvl       (lvl_sync[ch]),
      .wr_en     (wr_en),
      .wr_type   (wr_data[BITS_PER_CH*ch]),
      .wr_flag   (wr_data[BITS_PER_CH*ch+1]),
      .ack_valid (ack_valid),
      .ack_addr  (ack_addr),
      .trig_o    (trig[ch]),
      .flag_o    (flag[ch])
    );

    assign rd_data[BITS_PER_CH*ch]   = trig[ch];
    assign rd_data[BITS_PER_CH*ch+1] = flag[ch];
  end

  assign irq_req = flag;

  // R1: flags stay low while pins idle high after reset in level mode
  a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && $stable(irq_req) && (irq_req == '0) && (lvl_sync == '1))
      |=> (irq_req == '0) || $past(wr_en) || ($past(lvl_sync) != '1));
endmodule

// File: tb/ext_irq_detect_tb.sv
module ext_irq_detect_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  irq_pin_n = 2'b11;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_data = '0;
  logic [3:0]  rd_data;
  logic        ack_valid = 1'b0;
  logic [15:0] ack_addr = '0;
  logic [1:0]  irq_req;

  int total = 0;
  int bad = 0;

  // bench model state
  logic [1:0] m_s1, m_s2, m_prev, m_type, m_flag;

  always #4 clk = ~clk;

  ext_irq_detect u_dut (
    .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .ack_valid(ack_valid),
    .ack_addr(ack_addr), .irq_req(irq_req)
  );

  function automatic logic [15:0] vec_of(input int c);
    return (c == 0) ? 16'h0003 : 16'h0013;
  endfunction

  function automatic logic [3:0] pack_nib(input logic [1:0] t, input logic [1:0] f);
    return {f[1], t[1], f[0], t[0]};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_edge();
    for (int c = 0; c < 2; c++) begin
      logic fall, hit;
      fall = m_prev[c] & ~m_s2[c];
      hit  = ack_valid && (ack_addr == vec_of(c));
      if (wr_en) begin
        m_type[c] = wr_data[2*c];
        m_flag[c] = wr_data[2*c+1];
      end else if (m_type[c]) begin
        if (fall) m_flag[c] = 1'b1;
        else if (hit) m_flag[c] = 1'b0;
      end else m_flag[c] = ~m_s2[c];
    end
    m_prev = m_s2;
    m_s2   = m_s1;
    m_s1   = irq_pin_n;
  endtask

  // called at a negedge; applies inputs across one posedge, checks at next negedge
  task automatic tick(input logic [1:0] pins, input logic we, input logic [3:0] wd,
                      input logic av, input logic [15:0] aa, input string req);
    irq_pin_n = pins; wr_en = we; wr_data = wd; ack_valid = av; ack_addr = aa;
    model_edge();
    @(posedge clk);
    @(negedge clk);
    check(req, {6'd0, irq_req}, {6'd0, m_flag});
    check(req, {4'd0, rd_data}, {4'd0, pack_nib(m_type, m_flag)});
    wr_en = 1'b0; ack_valid = 1'b0;
  endtask

  task automatic idle(input logic [1:0] pins, input int n, input string req);
    for (int i = 0; i < n; i++) tick(pins, 1'b0, 4'h0, 1'b0, 16'h0, req);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    m_s1 = 2'b11; m_s2 = 2'b11; m_prev = 2'b11; m_type = 2'b00; m_flag = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", {4'd0, rd_data}, 8'h00);
    check("R1", {6'd0, irq_req}, 8'h00);
    idle(2'b11, 3, "R1");

    // R2: both pins falling-edge mode
    tick(2'b11, 1'b1, 4'b0101, 1'b0, 16'h0, "R2");
    check("R2", {4'd0, rd_data}, 8'h05);

    // R3: pin 0 falls; flag visible after the third edge
    tick(2'b10, 1'b0, 4'h0, 1'b0, 16'h0, "R3");
    tick(2'b10, 1'b0, 4'h0, 1'b0, 16'h0, "R3");
    check("R3", {6'd0, irq_req}, 8'h00);
    tick(2'b10, 1'b0, 4'h0, 1'b0, 16'h0, "R3");
    check("R3", {6'd0, irq_req}, 8'h01);
    idle(2'b10, 4, "R3");
    check("R3", {6'd0, irq_req}, 8'h01);

    // R5: stray address and the other pin's vector
    tick(2'b10, 1'b0, 4'h0, 1'b1, 16'h0004, "R5");
    tick(2'b10, 1'b0, 4'h0, 1'b1, 16'h0013, "R5");
    check("R5", {6'd0, irq_req}, 8'h01);

    // R4: own vector clears
    tick(2'b10, 1'b0, 4'h0, 1'b1, 16'h0003, "R4");
    check("R4", {6'd0, irq_req}, 8'h00);

    // R6: edge detected in the same cycle as the acknowledge
    idle(2'b11, 4, "R6");
    tick(2'b10, 1'b0, 4'h0, 1'b0, 16'h0, "R6");
    tick(2'b10, 1'b0, 4'h0, 1'b0, 16'h0, "R6");
    tick(2'b10, 1'b0, 4'h0, 1'b1, 16'h0003, "R6");
    check("R6", {6'd0, irq_req}, 8'h01);

    // R8: write clearing the flag coincides with a pin 1 edge
    idle(2'b11, 4, "R8");
    tick(2'b01, 1'b0, 4'h0, 1'b0, 16'h0, "R8");
    tick(2'b01, 1'b0, 4'h0, 1'b0, 16'h0, "R8");
    tick(2'b01, 1'b1, 4'b0101, 1'b0, 16'h0, "R8");
    check("R8", {6'd0, irq_req}, 8'h00);
    tick(2'b11, 1'b1, 4'b1101, 1'b1, 16'h0013, "R8");
    check("R8", {6'd0, irq_req}, 8'h02);

    // R9: acknowledge pin 1 leaves pin 0 alone
    tick(2'b11, 1'b1, 4'b1111, 1'b0, 16'h0, "R9");
    tick(2'b11, 1'b0, 4'h0, 1'b1, 16'h0013, "R9");
    check("R9", {6'd0, irq_req}, 8'h01);

    // R7: level mode, acknowledge while low has no lasting effect
    tick(2'b11, 1'b1, 4'b0000, 1'b0, 16'h0, "R7");
    idle(2'b10, 3, "R7");
    check("R7", {6'd0, irq_req}, 8'h01);
    tick(2'b10, 1'b0, 4'h0, 1'b1, 16'h0003, "R7");
    tick(2'b10, 1'b0, 4'h0, 1'b0, 16'h0, "R7");
    check("R7", {6'd0, irq_req}, 8'h01);
    idle(2'b11, 3, "R7");
    check("R7", {6'd0, irq_req}, 8'h00);

    // R9: random mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      logic [1:0]  p;
      logic        we, av;
      logic [3:0]  wd;
      logic [15:0] aa;
      int unsigned r;
      p  = (($urandom() % 4) == 0) ? 2'($urandom()) : irq_pin_n;
      we = (($urandom() % 16) == 0);
      wd = 4'($urandom());
      av = (($urandom() % 4) == 0);
      r  = $urandom() % 3;
      aa = (r == 0) ? 16'h0003 : (r == 1) ? 16'h0013 : 16'($urandom());
      tick(p, we, wd, av, aa, "R9");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule